// File: doc/BRIEF.md
# Pin Interrupt Trigger Unit

This block turns four asynchronous external pins into four interrupt request lines. Each source has its own 2-bit trigger code. The code selects one of four trigger conditions: the pin is high, the pin is low, the pin rises, or the pin falls. Every pin first passes through a two-flop synchroniser. Edge detection compares the synchronised value with its value one cycle earlier.

In the two level modes the request simply mirrors the synchronised pin. In the two edge modes a detected edge sets a sticky flag. The flag holds until software writes a 1 to that source's bit in a write-only clear register. Each request is then gated by a per-source enable bit.

Software reaches the block through a small register bus. It has a 2-bit address, a single-cycle write strobe and a combinational read port. The block carries no data stream, so there is no valid/ready handshake and no back-pressure. Every bus write is accepted in the cycle its strobe is high.

Top module: `pin_trigger_unit`

## Requirements
- R1: The trigger-code register sits at address 0 and resets to 0x00. Source n owns bits [2n+1:2n], so source 0 uses bits 1:0 and source 3 uses bits 7:6. Reads return the stored codes, with bits 31:8 reading as zero.
- R2: The trigger codes mean: 00 is a high level, 01 is a low level, 10 is a rising edge and 11 is a falling edge. An edge of the opposite direction does not trigger.
- R3: The enable register sits at address 1, uses bits 3:0 and resets to 0. Request n is high only while enable bit n is set. An edge arriving while a source is disabled is still latched, and it shows on the request once the source is enabled.
- R4: Each pin is synchronised by two flops. In a level mode the request reflects a pin change after the second rising clock edge and not after the first. It follows the pin back with no latching.
- R5: An edge is detected when the synchronised pin differs from its previous-cycle value in the selected direction. The request appears after the third clock edge following the pin change. It then stays high after the pin returns.
- R6: Writing address 2 clears the edge flag of every source whose data bit is 1, and leaves sources whose bit is 0 untouched. Address 2 reads as zero.
- R7: In the level modes, writes to the clear register have no effect on the request.
- R8: If an edge is detected in the same cycle as a clear write for that source, the edge wins and the flag stays set.
- R9: Writing a different trigger code to a source clears its edge flag. Rewriting the same code leaves the flag as it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register select: 0 trigger codes, 1 enables, 2 flag clear |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_in | input | 4 | Asynchronous external pins |
| irq_out | output | 4 | Per-source interrupt requests |

## Verification
The bench samples the requests one edge before the synchroniser delay expires and again just after it, which exposes a design with one flop too few or too many. It drives a clear write into exactly the cycle an edge is detected. A design that let the clear win would drop that request. It also rewrites an unchanged trigger code and then a changed one. A design that cleared on every write would lose a pending edge, and one that never cleared would keep a stale request after a mode switch. Finally, it latches an edge while the source is disabled and clears with zeros in the target bit. A wrong design would either lose the request or clear the wrong source.

// File: rtl/pin_trigger_pkg.sv
package pin_trigger_pkg;
  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  localparam logic [1:0] ADDR_MODE   = 2'd0;
  localparam logic [1:0] ADDR_ENABLE = 2'd1;
  localparam logic [1:0] ADDR_CLEAR  = 2'd2;
endpackage

// File: rtl/pin_trigger_sync.sv
module pin_trigger_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/pin_trigger_lane.sv
module pin_trigger_lane
  import pin_trigger_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_sync,
  input  trig_mode_e mode,
  input  logic       mode_chg,
  input  logic       flag_clr,
  input  logic       enable,
  output logic       irq
);
  logic prev_q;
  logic flag_q;
  logic edge_hit;
  logic level_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_sync;
  end

  always_comb begin
    unique case (mode)
      TRIG_RISE: edge_hit = pin_sync & ~prev_q;
      TRIG_FALL: edge_hit = ~pin_sync & prev_q;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign level_hit = (mode == TRIG_HIGH) ? pin_sync : ~pin_sync;

  // Mode change first, then a fresh edge, then the clear request.
  always_ff @(posedge clk) begin
    if (!rst_n)         flag_q <= 1'b0;
    else if (mode_chg)  flag_q <= 1'b0;
    else if (edge_hit)  flag_q <= 1'b1;
    else if (flag_clr)  flag_q <= 1'b0;
  end

  assign irq = enable & (mode[1] ? flag_q : level_hit);

  a_r9_mode_change_clears: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> !flag_q);
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && flag_clr && !mode_chg) |=> flag_q);
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr && !mode_chg) |=> flag_q);
  a_r7_level_never_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !mode[1] |-> !flag_q);
endmodule

// File: rtl/pin_trigger_unit.sv
module pin_trigger_unit
  import pin_trigger_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int BUS_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic [N_SRC-1:0] pin_in,
  output logic [N_SRC-1:0] irq_out
);
  localparam int MODE_W = 2 * N_SRC;

  logic [MODE_W-1:0] mode_q;
  logic [N_SRC-1:0]  en_q;
  logic [N_SRC-1:0]  pin_sync;
  logic [N_SRC-1:0]  mode_chg;
  logic [N_SRC-1:0]  flag_clr;
  logic              wr_mode, wr_en, wr_clr;

  assign wr_mode = bus_wr && (bus_addr == ADDR_MODE);
  assign wr_en   = bus_wr && (bus_addr == ADDR_ENABLE);
  assign wr_clr  = bus_wr && (bus_addr == ADDR_CLEAR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_mode) mode_q <= bus_wdata[MODE_W-1:0];
      if (wr_en)   en_q   <= bus_wdata[N_SRC-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_MODE:   bus_rdata[MODE_W-1:0] = mode_q;
      ADDR_ENABLE: bus_rdata[N_SRC-1:0]  = en_q;
      default:     bus_rdata = '0;
    endcase
  end

  pin_trigger_sync #(.WIDTH(N_SRC), .STAGES(SYNC_N)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pin_sync)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_lane
    trig_mode_e lane_mode;
    assign lane_mode   = trig_mode_e'(mode_q[2*i +: 2]);
    assign mode_chg[i] = wr_mode && (bus_wdata[2*i +: 2] != mode_q[2*i +: 2]);
    assign flag_clr[i] = wr_clr && bus_wdata[i];

    pin_trigger_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_sync (pin_sync[i]),
      .mode     (lane_mode),
      .mode_chg (mode_chg[i]),
      .flag_clr (flag_clr[i]),
      .enable   (en_q[i]),
      .irq      (irq_out[i])
    );

    a_r4_high_level_lag: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[i] && lane_mode == TRIG_HIGH) |-> (irq_out[i] == $past(pin_in[i], 2)));
    a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_q[i]) |-> !irq_out[i]);
  end

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[BUS_W-1:MODE_W] == '0);
endmodule

// File: tb/pin_trigger_unit_test.sv
module pin_trigger_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pin_in = '0;
  logic [3:0]  irq_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  typedef struct {
    bit          is_read;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pin_trigger_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq_out(irq_out)
  );

  // Monitor: compares queued expectations just after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it  = sb_q.pop_front();
        act = it.is_read ? bus_rdata : {28'd0, irq_out};
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  task automatic push(bit rd, logic [31:0] exp, string tag);
    item_t it;
    it.is_read = rd; it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic bus_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic expect_read(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_addr = a;
    push(1'b1, exp, tag);
  endtask

  task automatic expect_irq(logic [3:0] exp, string tag);
    push(1'b0, {28'd0, exp}, tag);
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    pin_in[idx] = v;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // Reset state
    expect_read(2'd0, 32'h0, "R1 mode reset");
    expect_read(2'd1, 32'h0, "R3 enable reset");
    expect_read(2'd2, 32'h0, "R6 clear reads zero");
    expect_irq(4'h0, "R3 reset idle");

    // lane0 high, lane1 low, lane2 rise, lane3 fall
    bus_write(2'd0, 32'hFFFF_FFE4);
    expect_read(2'd0, 32'h0000_00E4, "R1 mode readback reserved zero");
    expect_irq(4'h0, "R3 all disabled");
    bus_write(2'd1, 32'hF);
    expect_irq(4'b0010, "R2 low level active on low pin");

    // R4 level latency and no latching
    set_pin(0, 1'b1);
    wait_cyc(1); expect_irq(4'b0010, "R4 not after one edge");
    wait_cyc(1); expect_irq(4'b0011, "R4 after two edges");
    set_pin(0, 1'b0);
    wait_cyc(2); expect_irq(4'b0010, "R4 follows pin back");
    set_pin(0, 1'b1);
    wait_cyc(2);
    bus_write(2'd2, 32'hF);
    expect_irq(4'b0011, "R7 clear ignored in level mode");
    set_pin(0, 1'b0);
    set_pin(1, 1'b1);
    wait_cyc(2); expect_irq(4'b0000, "R2 low level released");

    // R5 rising edge on lane2
    set_pin(2, 1'b1);
    wait_cyc(2); expect_irq(4'b0000, "R5 not before third edge");
    wait_cyc(1); expect_irq(4'b0100, "R5 rising edge latched");
    set_pin(2, 1'b0);
    wait_cyc(3); expect_irq(4'b0100, "R5 sticky after pin falls");
    bus_write(2'd2, 32'h0B);
    expect_irq(4'b0100, "R6 zero bit leaves flag");
    bus_write(2'd2, 32'h04);
    expect_irq(4'b0000, "R6 one bit clears flag");

    // lane3 falling
    set_pin(3, 1'b1);
    wait_cyc(3); expect_irq(4'b0000, "R2 rise ignored in fall mode");
    set_pin(3, 1'b0);
    wait_cyc(3); expect_irq(4'b1000, "R2 falling edge latched");
    bus_write(2'd2, 32'h08);
    expect_irq(4'b0000, "R6 clear lane3");

    // R8 edge and clear in the same cycle
    set_pin(2, 1'b1);
    wait_cyc(1);
    bus_write(2'd2, 32'h04);
    expect_irq(4'b0100, "R8 edge beats clear");
    bus_write(2'd2, 32'h04);
    set_pin(2, 1'b0);
    wait_cyc(3); expect_irq(4'b0000, "R2 fall ignored in rise mode");

    // R3 capture while disabled
    bus_write(2'd1, 32'hB);
    set_pin(2, 1'b1);
    wait_cyc(3); expect_irq(4'b0000, "R3 disabled source quiet");
    bus_write(2'd1, 32'hF);
    expect_irq(4'b0100, "R3 edge captured while disabled");

    // R9 mode rewrites
    bus_write(2'd0, 32'hE4);
    expect_irq(4'b0100, "R9 same code keeps flag");
    bus_write(2'd0, 32'hF4);
    expect_irq(4'b0000, "R9 changed code clears flag");
    set_pin(2, 1'b0);
    wait_cyc(3); expect_irq(4'b0100, "R2 falling edge in new mode");
    bus_write(2'd0, 32'hC4);
    expect_irq(4'b0000, "R9 switch to high level on low pin");
    bus_write(2'd0, 32'hF4);
    expect_irq(4'b0000, "R9 no stale flag after round trip");

    wait_cyc(2);
    #2;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule